// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings a single-data-rate SDRAM array out of power-up one row at a time. A start pulse launches the run. The sequencer waits for supplies and clocks to settle, then walks a table of cumulative row end boundaries. Each row whose end lies above its start receives the startup command train, followed by a write and read-back of a fixed check word. When every row has been visited, the sequencer selects the slow periodic refresh interval and raises its completion flag. From then on, an internal interval counter emits refresh requests.

Each command leaves the block as a 3-bit mode code with a one-cycle access strobe. The strobe carries the row's base address, which is the start boundary in 32 MiB units. The mode-register access adds a fixed offset, so the mode value travels on the address lines.

States and transitions: IDLE goes to PWRUP on start. PWRUP goes to ROW when the settle count ends. ROW goes to NOP for a populated row, or to NEXT for an empty one. Then NOP goes to PRE, PRE to CBR, and CBR repeats itself until eight refreshes have been issued before going to MRS. MRS goes to NORM, NORM to WR, WR to RD and RD to NEXT. NEXT goes back to ROW, or to REFON after the last row. REFON goes to DONE, and DONE goes back to PWRUP on start.

Top module: `sdram_init_seq`

## Requirements
- R1: After reset the block is idle: busy, init_done, mismatch, all strobes, addr and wr_data are 0, cmd_mode is 0 (self refresh) and ref_mode is 0.
- R2: An accepted start is followed by exactly PWRUP_CYC cycles with busy high, cmd_mode 1 and no strobe. The default of 26600 cycles is 200 us at 133 MHz.
- R3: Each populated row receives a fixed train of steps, each lasting STEP_CYC cycles, with its strobe (cmd_issue) in the first cycle. The order and cmd_mode codes are: NOP = 1, precharge-all = 2, eight auto-refresh steps = 6, mode register set = 3, normal = 7. In the cycles between steps cmd_mode reads 1.
- R4: The addr output carries the row base, which is the start boundary shifted left by 25. During the mode-register step it carries the row base plus 0x1D0. It reads 0 in every cycle without a strobe.
- R5: A row is populated only when its end boundary is strictly greater than its start boundary. The first row starts at 0, and each row starts at the previous row's end boundary. An unpopulated row costs two cycles and issues no strobe.
- R6: After the normal step, wr_en pulses with wr_data 0x55AA55AA at the row base, and STEP_CYC cycles later rd_en pulses at the same address. Both occur in mode 7.
- R7: If rd_data differs from 0x55AA55AA in the rd_en cycle, mismatch rises on the next cycle and stays high. The run still continues with the remaining rows. Mismatch clears only when a new start is accepted.
- R8: One cycle after the last row is handled, ref_mode becomes 1, init_done rises and busy falls, all in the same cycle. init_done is never high while ref_mode is not 1.
- R9: While ref_mode is 1, ref_req is a single-cycle pulse: first in the 2075th cycle of the done state, then every 2075 cycles. While ref_mode is 0, ref_req stays low.
- R10: A start pulse while busy is ignored and the run proceeds unchanged. A start is accepted in the idle and done states, and busy never coincides with init_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launches a run when not busy |
| row_end | input | NUM_ROWS*BND_W | Cumulative end boundary per row, row 0 in the low bits |
| rd_data | input | 32 | Read-back data, valid in the rd_en cycle |
| cmd_mode | output | 3 | Command mode code |
| cmd_issue | output | 1 | Command access strobe |
| wr_en | output | 1 | Check-word write strobe |
| rd_en | output | 1 | Check-word read strobe |
| addr | output | BND_W+25 | Access address |
| wr_data | output | 32 | Write data (check word during wr_en) |
| ref_mode | output | 3 | Refresh select: 0 off, 1 slow, 2 fast, 7 burst |
| ref_req | output | 1 | Periodic refresh request pulse |
| busy | output | 1 | Run in progress |
| init_done | output | 1 | All rows initialized and refresh enabled |
| mismatch | output | 1 | Sticky check-word read-back error |

## Verification
The bench runs three boundary tables. The first has an empty second row, which shows that skipping works while start boundaries still move forward. The second has empty first and third rows and a large final end boundary, which exposes base address shifting and the row-index limit. The third has a boundary lower than its predecessor, which separates the strictly-greater comparison from a not-equal test. The second run corrupts the read-back data, so it tells sticky mismatch apart from a per-row flag. The third run starts again from done and shows that the flag clears. A start pulse in the middle of a run, and two refresh periods after completion, cover the ignore rule and the request interval.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    localparam logic [2:0] MODE_SELF   = 3'd0;
    localparam logic [2:0] MODE_NOP    = 3'd1;
    localparam logic [2:0] MODE_PRE    = 3'd2;
    localparam logic [2:0] MODE_MRS    = 3'd3;
    localparam logic [2:0] MODE_CBR    = 3'd6;
    localparam logic [2:0] MODE_NORMAL = 3'd7;

    localparam logic [2:0] REF_OFF   = 3'd0;
    localparam logic [2:0] REF_SLOW  = 3'd1;
    localparam logic [2:0] REF_FAST  = 3'd2;
    localparam logic [2:0] REF_BURST = 3'd7;

    localparam logic [31:0] CHECK_WORD = 32'h55AA_55AA;
    localparam int          MRS_OFFSET = 'h1D0;
    localparam int          ROW_SHIFT  = 25;

    typedef enum logic [3:0] {
        ST_IDLE, ST_PWRUP, ST_ROW, ST_NOP, ST_PRE, ST_CBR, ST_MRS,
        ST_NORM, ST_WR, ST_RD, ST_NEXT, ST_REFON, ST_DONE
    } seq_state_e;

endpackage

// File: rtl/sdram_wait_timer.sv
module sdram_wait_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (restart)
            count <= '0;
        else if (count != '1)
            count <= count + 1'b1;
    end
endmodule

// File: rtl/sdram_ref_gen.sv
module sdram_ref_gen
    import sdram_init_pkg::*;
#(
    parameter int SLOW_CYC  = 2075,
    parameter int FAST_CYC  = 1037,
    parameter int BURST_CYC = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] sel,
    output logic       ref_req
);
    localparam int MAX_AB = (SLOW_CYC > FAST_CYC) ? SLOW_CYC : FAST_CYC;
    localparam int MAX_L  = (MAX_AB > BURST_CYC) ? MAX_AB : BURST_CYC;
    localparam int W      = $clog2(MAX_L + 1);

    logic [W-1:0] cnt;
    logic [W-1:0] limit;
    logic         en;

    always_comb begin
        en    = 1'b1;
        limit = '0;
        case (sel)
            REF_SLOW:  limit = W'(SLOW_CYC - 1);
            REF_FAST:  limit = W'(FAST_CYC - 1);
            REF_BURST: limit = W'(BURST_CYC - 1);
            default:   en    = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !en)
            cnt <= '0;
        else if (cnt == limit)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign ref_req = en && (cnt == limit);
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int NUM_ROWS      = 4,
    parameter int BND_W         = 7,
    parameter int PWRUP_CYC     = 26600,
    parameter int STEP_CYC      = 4,
    parameter int CBR_COUNT     = 8,
    parameter int REF_SLOW_CYC  = 2075,
    parameter int REF_FAST_CYC  = 1037,
    parameter int REF_BURST_CYC = 128
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic [NUM_ROWS*BND_W-1:0]     row_end,
    input  logic [31:0]                   rd_data,
    output logic [2:0]                    cmd_mode,
    output logic                          cmd_issue,
    output logic                          wr_en,
    output logic                          rd_en,
    output logic [BND_W+ROW_SHIFT-1:0]    addr,
    output logic [31:0]                   wr_data,
    output logic [2:0]                    ref_mode,
    output logic                          ref_req,
    output logic                          busy,
    output logic                          init_done,
    output logic                          mismatch
);
    localparam int ADDR_W = BND_W + ROW_SHIFT;
    localparam int IDX_W  = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1;
    localparam int T_MAX  = (PWRUP_CYC > STEP_CYC) ? PWRUP_CYC : STEP_CYC;
    localparam int CNT_W  = $clog2(T_MAX + 1);
    localparam int CBR_W  = $clog2(CBR_COUNT + 1);

    seq_state_e        state, nxt;
    logic [CNT_W-1:0]  tcount;
    logic              step_restart, cbr_again;
    logic [IDX_W-1:0]  row_idx;
    logic [BND_W-1:0]  row_start, row_stop;
    logic [CBR_W-1:0]  cbr_idx;
    logic              step_first, step_last, pwr_last, row_last, cbr_last;
    logic              accept, strobe;
    logic [ADDR_W-1:0] row_base;

    assign row_stop   = row_end[int'(row_idx)*BND_W +: BND_W];
    assign step_first = (tcount == '0);
    assign step_last  = (tcount == CNT_W'(STEP_CYC - 1));
    assign pwr_last   = (tcount == CNT_W'(PWRUP_CYC - 1));
    assign row_last   = (row_idx == IDX_W'(NUM_ROWS - 1));
    assign cbr_last   = (cbr_idx == CBR_W'(CBR_COUNT - 1));
    assign accept     = start && ((state == ST_IDLE) || (state == ST_DONE));
    assign row_base   = ADDR_W'(row_start) << ROW_SHIFT;

    // next-state selection
    always_comb begin
        nxt       = state;
        cbr_again = 1'b0;
        unique case (state)
            ST_IDLE, ST_DONE: if (start) nxt = ST_PWRUP;
            ST_PWRUP: if (pwr_last) nxt = ST_ROW;
            ST_ROW:   nxt = (row_stop > row_start) ? ST_NOP : ST_NEXT;
            ST_NOP:   if (step_last) nxt = ST_PRE;
            ST_PRE:   if (step_last) nxt = ST_CBR;
            ST_CBR: begin
                if (step_last) begin
                    if (cbr_last) nxt = ST_MRS;
                    else          cbr_again = 1'b1;
                end
            end
            ST_MRS:   if (step_last) nxt = ST_NORM;
            ST_NORM:  if (step_last) nxt = ST_WR;
            ST_WR:    if (step_last) nxt = ST_RD;
            ST_RD:    if (step_last) nxt = ST_NEXT;
            ST_NEXT:  nxt = row_last ? ST_REFON : ST_ROW;
            ST_REFON: nxt = ST_DONE;
            default:  nxt = ST_IDLE;
        endcase
    end

    assign step_restart = (nxt != state) || cbr_again;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    sdram_wait_timer #(.W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (step_restart),
        .count   (tcount)
    );

    // row walk, refresh-count, refresh select and check result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_idx   <= '0;
            row_start <= '0;
            cbr_idx   <= '0;
            ref_mode  <= REF_OFF;
            mismatch  <= 1'b0;
        end else begin
            if (accept) begin
                row_idx   <= '0;
                row_start <= '0;
                ref_mode  <= REF_OFF;
                mismatch  <= 1'b0;
            end
            if (state == ST_NEXT) begin
                row_start <= row_stop;
                if (!row_last) row_idx <= row_idx + IDX_W'(1);
            end
            if (state == ST_PRE) cbr_idx <= '0;
            else if (cbr_again)  cbr_idx <= cbr_idx + CBR_W'(1);
            if ((state == ST_RD) && step_first && (rd_data != CHECK_WORD))
                mismatch <= 1'b1;
            if (state == ST_REFON) ref_mode <= REF_SLOW;
        end
    end

    // outputs
    always_comb begin
        cmd_mode  = MODE_NOP;
        cmd_issue = 1'b0;
        wr_en     = 1'b0;
        rd_en     = 1'b0;
        busy      = 1'b1;
        init_done = 1'b0;
        unique case (state)
            ST_IDLE: begin cmd_mode = MODE_SELF; busy = 1'b0; end
            ST_DONE: begin cmd_mode = MODE_NORMAL; busy = 1'b0; init_done = 1'b1; end
            ST_NOP:  cmd_issue = step_first;
            ST_PRE:  begin cmd_mode = MODE_PRE;    cmd_issue = step_first; end
            ST_CBR:  begin cmd_mode = MODE_CBR;    cmd_issue = step_first; end
            ST_MRS:  begin cmd_mode = MODE_MRS;    cmd_issue = step_first; end
            ST_NORM: begin cmd_mode = MODE_NORMAL; cmd_issue = step_first; end
            ST_WR:   begin cmd_mode = MODE_NORMAL; wr_en = step_first; end
            ST_RD:   begin cmd_mode = MODE_NORMAL; rd_en = step_first; end
            default: ;
        endcase
        strobe  = cmd_issue | wr_en | rd_en;
        addr    = '0;
        if (strobe)
            addr = (state == ST_MRS) ? (row_base + ADDR_W'(MRS_OFFSET)) : row_base;
        wr_data = wr_en ? CHECK_WORD : 32'h0;
    end

    sdram_ref_gen #(
        .SLOW_CYC  (REF_SLOW_CYC),
        .FAST_CYC  (REF_FAST_CYC),
        .BURST_CYC (REF_BURST_CYC)
    ) u_ref (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (ref_mode),
        .ref_req (ref_req)
    );
endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk
    import sdram_init_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start,
    input logic [2:0]           cmd_mode,
    input logic                 cmd_issue,
    input logic                 wr_en,
    input logic                 rd_en,
    input logic [ROW_SHIFT-1:0] addr_low,
    input logic [31:0]          wr_data,
    input logic [2:0]           ref_mode,
    input logic                 ref_req,
    input logic                 busy,
    input logic                 init_done,
    input logic                 mismatch
);
    assert_strobe_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_issue, wr_en, rd_en}));

    assert_strobe_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_issue || wr_en || rd_en) |-> busy);

    assert_mrs_offset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_issue && (cmd_mode == MODE_MRS)) |-> (addr_low == ROW_SHIFT'(MRS_OFFSET)));

    assert_check_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ((wr_data == CHECK_WORD) && (addr_low == '0) && (cmd_mode == MODE_NORMAL)));

    assert_mismatch_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mismatch && !start) |=> mismatch);

    assert_done_after_ref_R8: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (ref_mode == REF_SLOW));

    assert_ref_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req |=> !ref_req);

    assert_busy_done_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && init_done));
endmodule

bind sdram_init_seq sdram_init_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .cmd_mode  (cmd_mode),
    .cmd_issue (cmd_issue),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr_low  (addr[sdram_init_pkg::ROW_SHIFT-1:0]),
    .wr_data   (wr_data),
    .ref_mode  (ref_mode),
    .ref_req   (ref_req),
    .busy      (busy),
    .init_done (init_done),
    .mismatch  (mismatch)
);

// File: tb/sdram_init_seq_bench.sv
`timescale 1ns/1ps
module sdram_init_seq_bench;
    localparam int NR    = 4;
    localparam int BW    = 7;
    localparam int PW    = 100;
    localparam int ST    = 3;
    localparam int RSLOW = 2075;
    localparam logic [31:0] WORD = 32'h55AA_55AA;

    typedef struct packed {
        logic        busy;
        logic        done;
        logic [2:0]  mode;
        logic        iss;
        logic        wr;
        logic        rd;
        logic [31:0] addr;
        logic [31:0] wd;
        logic [2:0]  rm;
        logic        mm;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [NR*BW-1:0] row_end = '0;
    logic [31:0]      rd_data;
    logic [2:0]       cmd_mode;
    logic             cmd_issue, wr_en, rd_en;
    logic [31:0]      addr;
    logic [31:0]      wr_data;
    logic [2:0]       ref_mode;
    logic             ref_req, busy, init_done, mismatch;

    int   n_chk = 0;
    int   n_bad = 0;
    bit   checking = 1'b0;
    bit   finished = 1'b0;
    bit   m_fin = 1'b0;
    logic m_mm = 1'b0;
    logic p_mm = 1'b0;
    bit   m_flip = 1'b0;
    int   m_rc = 0;
    logic [31:0] mem_q = 32'h0;
    exp_t  sched[$];
    string tags[$];

    always #4 clk = ~clk;

    sdram_init_seq #(
        .NUM_ROWS (NR),
        .BND_W    (BW),
        .PWRUP_CYC(PW),
        .STEP_CYC (ST)
    ) u_sdram_init_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .row_end(row_end), .rd_data(rd_data),
        .cmd_mode(cmd_mode), .cmd_issue(cmd_issue), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wr_data(wr_data), .ref_mode(ref_mode), .ref_req(ref_req),
        .busy(busy), .init_done(init_done), .mismatch(mismatch)
    );

    // simple one-word memory; optional bit corruption on read-back
    always @(posedge clk) if (wr_en) mem_q <= wr_data;
    assign rd_data = mem_q ^ (m_flip ? 32'h0000_0100 : 32'h0);

    function automatic exp_t mk(input logic b, input logic d, input logic [2:0] m,
                                input logic i, input logic w, input logic r,
                                input logic [31:0] a, input logic [31:0] wd,
                                input logic [2:0] rm, input logic mm);
        exp_t e;
        e = '{busy:b, done:d, mode:m, iss:i, wr:w, rd:r, addr:a, wd:wd, rm:rm, mm:mm};
        return e;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    task automatic push(input exp_t e, input string tg);
        sched.push_back(e);
        tags.push_back(tg);
    endtask

    task automatic add_step(input logic [2:0] md, input logic iss, input logic wr,
                            input logic rd, input logic [31:0] ad, input string tg);
        for (int k = 0; k < ST; k++) begin
            push(mk(1'b1, 1'b0, md, (k == 0) ? iss : 1'b0, (k == 0) ? wr : 1'b0,
                    (k == 0) ? rd : 1'b0, (k == 0) ? ad : 32'h0,
                    (k == 0 && wr) ? WORD : 32'h0, 3'd0, p_mm), tg);
            if (k == 0 && rd && m_flip) p_mm = 1'b1;
        end
    endtask

    // expected schedule built from the requirements
    task automatic plan_run(input logic [NR*BW-1:0] ends);
        logic [BW-1:0] prev, e;
        logic [31:0]   base;
        p_mm = 1'b0;
        for (int k = 0; k < PW; k++)
            push(mk(1'b1, 1'b0, 3'd1, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0, 3'd0, 1'b0), "R2");
        prev = '0;
        for (int r = 0; r < NR; r++) begin
            e = ends[r*BW +: BW];
            push(mk(1'b1, 1'b0, 3'd1, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0, 3'd0, p_mm), "R5");
            if (e > prev) begin
                base = {prev, 25'b0};
                add_step(3'd1, 1'b1, 1'b0, 1'b0, base, "R3");
                add_step(3'd2, 1'b1, 1'b0, 1'b0, base, "R3");
                for (int c = 0; c < 8; c++) add_step(3'd6, 1'b1, 1'b0, 1'b0, base, "R3");
                add_step(3'd3, 1'b1, 1'b0, 1'b0, base + 32'h1D0, "R4");
                add_step(3'd7, 1'b1, 1'b0, 1'b0, base, "R3");
                add_step(3'd7, 1'b0, 1'b1, 1'b0, base, "R6");
                add_step(3'd7, 1'b0, 1'b0, 1'b1, base, m_flip ? "R7" : "R6");
            end
            push(mk(1'b1, 1'b0, 3'd1, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0, 3'd0, p_mm), "R5");
            prev = e;
        end
        push(mk(1'b1, 1'b0, 3'd1, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0, 3'd0, p_mm), "R8");
        m_fin = 1'b1;
        m_rc  = 0;
    endtask

    // cycle-by-cycle comparison
    exp_t  e_x, a_x;
    string t_x;
    logic  req_x;
    always @(negedge clk) begin
        if (checking && !finished) begin
            if (sched.size() > 0) begin
                e_x   = sched.pop_front();
                t_x   = tags.pop_front();
                req_x = 1'b0;
            end else if (m_fin) begin
                e_x   = mk(1'b0, 1'b1, 3'd7, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0, 3'd1, m_mm);
                t_x   = "R8";
                req_x = ((m_rc % RSLOW) == RSLOW - 1);
                m_rc++;
            end else begin
                e_x   = mk(1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0, 3'd0, m_mm);
                t_x   = "R1";
                req_x = 1'b0;
            end
            m_mm = e_x.mm;
            a_x  = mk(busy, init_done, cmd_mode, cmd_issue, wr_en, rd_en, addr,
                      wr_data, ref_mode, mismatch);
            n_chk++;
            if (a_x !== e_x) begin
                n_bad++;
                $display("FAIL %s outputs: actual=%h expected=%h", t_x, a_x, e_x);
            end
            n_chk++;
            if (ref_req !== req_x) begin
                n_bad++;
                $display("FAIL R9 ref_req: actual=%b expected=%b", ref_req, req_x);
            end
        end
    end

    task automatic launch(input logic [NR*BW-1:0] ends, input bit flip);
        @(negedge clk); #1;
        row_end = ends;
        m_flip  = flip;
        start   = 1'b1;
        plan_run(ends);
        @(negedge clk); #1;
        start = 1'b0;
    endtask

    task automatic wait_sched;
        while (sched.size() > 0) @(negedge clk);
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        #1 rst_n = 1'b1;
        checking = 1'b1;
        repeat (4) @(negedge clk);
        #2 chk(busy === 1'b0 && cmd_mode === 3'd0 && ref_mode === 3'd0, "R1", "idle state",
               {61'b0, busy, init_done, mismatch}, 64'h0);

        // run A: rows 0..2, 2..2 (empty), 2..5, 5..8
        launch({7'd8, 7'd5, 7'd2, 7'd2}, 1'b0);
        repeat (50) @(negedge clk);
        #1 start = 1'b1;
        @(negedge clk); #1 start = 1'b0;
        #1 chk(busy === 1'b1, "R10", "start ignored while busy", {63'b0, busy}, 64'h1);
        wait_sched();
        repeat (2) @(negedge clk);
        #2 chk(init_done === 1'b1 && ref_mode === 3'd1, "R8", "completion flags",
               {60'b0, init_done, ref_mode}, {60'b0, 1'b1, 3'd1});
        repeat (2 * RSLOW + 20) @(negedge clk);

        // run B: restart from done, empty rows, high boundary, corrupted read-back
        launch({7'd127, 7'd3, 7'd3, 7'd0}, 1'b1);
        wait_sched();
        repeat (10) @(negedge clk);
        #2 chk(mismatch === 1'b1, "R7", "mismatch sticky after run", {63'b0, mismatch}, 64'h1);

        // run C: falling boundary, clean read-back clears mismatch
        launch({7'd3, 7'd3, 7'd1, 7'd4}, 1'b0);
        repeat (3) @(negedge clk);
        #2 chk(mismatch === 1'b0, "R7", "mismatch cleared on start", {63'b0, mismatch}, 64'h0);
        wait_sched();
        repeat (20) @(negedge clk);
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL R8 watchdog: actual=running expected=finished");
            summary();
            $finish;
        end
    end
endmodule